// File: doc/BRIEF.md
# Two-Button Duty-Cycle Stepper

This block turns two mechanical push buttons into an 8-bit duty-cycle setting for a PWM compare register. One button lowers the setting and the other raises it, by a fixed step of 15 for each complete press. Each raw button line passes through a two-flop synchroniser and a counter-based debouncer. The step is applied only when the button is let go, so holding a button down never repeats or rushes the change.

The setting starts at 0. A lowering press is honoured only while the setting is above 0, and a raising press only while it is below 250. A lowering step from a value smaller than the step size stops at 0. When both buttons are down together, lowering wins. The raising press is then discarded, and no new press counts until both buttons are up again. Every change of the setting is marked by a one-cycle write strobe, so the compare register can load the new value directly.

Top module: `duty_stepper`

## Requirements
- R1: Both button inputs are active low: a 0 level is a press, and inputs held at 1 never change the duty value or raise the strobe.
- R2: A complete press-and-release of the lowering button subtracts 15 from the duty value, and one of the raising button adds 15.
- R3: No change appears while the button is still held; the change appears only after the debounced release (within DEBOUNCE_CYCLES + 6 clock cycles of the raw release).
- R4: A lowering press is applied only when the duty value is above 0; a press at 0 leaves the value at 0 with no strobe.
- R5: A raising press is applied only when the duty value is below 250; at 255 a press leaves the value at 255 with no strobe, while at 240 it gives 255.
- R6: After reset the duty value is 0 and the strobe is low.
- R7: A button level is accepted only after holding for DEBOUNCE_CYCLES consecutive synchronised cycles; shorter low pulses are ignored, and contact bounce around one press gives exactly one step.
- R8: The strobe is high for exactly one cycle in the cycle the duty value takes its new value, and it is never high when the value does not change.
- R9: If the lowering button is pressed while the raising button is held (in either order), only the lowering step is applied, on release of the lowering button; the raising press is dropped, and no press counts until both buttons are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_dn_n | input | 1 | Raw lowering button, active low |
| btn_up_n | input | 1 | Raw raising button, active low |
| duty_o | output | 8 | Current duty-cycle value for the PWM compare register |
| duty_wr_o | output | 1 | One-cycle strobe marking a new duty value |

## Verification
A debouncer that takes a level too early, or a press tracker that loses track of which button is held, shows up at the ports as a step during the hold, as a step after a short glitch, or as a missing or doubled step. All of these are visible within a few tens of cycles of the release. A wrong limit or priority decision shows as an off-by-15 value or as a stray strobe, in the cycle right after the debounced release. Each scenario therefore compares the value and the number of strobes both before and after each release, and the strobe count exposes duplicated or silent updates.

// File: rtl/duty_step_pkg.sv
package duty_step_pkg;
  localparam int NUM_BTN = 2;
  localparam int BTN_DN  = 0;
  localparam int BTN_UP  = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DN   = 2'd1,
    ST_UP   = 2'd2,
    ST_LOCK = 2'd3
  } arb_state_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int HOLD_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic pressed_o
);
  localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic          stable_q, stable_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differs;

  always_comb begin
    differs  = (level_i != stable_q);
    stable_d = stable_q;
    cnt_d    = '0;
    if (differs) begin
      if (cnt_q == LAST) begin
        stable_d = level_i;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      stable_q <= stable_d;
      cnt_q    <= cnt_d;
    end
  end

  assign pressed_o = ~stable_q;
endmodule

// File: rtl/duty_arbiter.sv
module duty_arbiter
  import duty_step_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int STEP     = 15,
  parameter int UP_LIMIT = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dn_p,
  input  logic             up_p,
  output logic [WIDTH-1:0] duty_o,
  output logic             wr_o
);
  localparam logic [WIDTH-1:0] STEP_W  = WIDTH'(STEP);
  localparam logic [WIDTH-1:0] LIMIT_W = WIDTH'(UP_LIMIT);
  localparam logic [WIDTH:0]   MAX_X   = {1'b0, {WIDTH{1'b1}}};

  arb_state_t       state_q, state_d;
  logic [WIDTH-1:0] duty_q, duty_d;
  logic             wr_q, wr_d;
  logic             do_dec, do_inc;
  logic [WIDTH:0]   sum;

  always_comb begin
    state_d = state_q;
    do_dec  = 1'b0;
    do_inc  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (dn_p)      state_d = ST_DN;
        else if (up_p) state_d = ST_UP;
      end
      ST_DN: begin
        if (!dn_p) begin
          do_dec  = 1'b1;
          state_d = up_p ? ST_LOCK : ST_IDLE;
        end
      end
      ST_UP: begin
        if (dn_p) begin
          state_d = ST_DN;
        end else if (!up_p) begin
          do_inc  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: begin
        if (!dn_p && !up_p) state_d = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    duty_d = duty_q;
    wr_d   = 1'b0;
    sum    = {1'b0, duty_q} + {1'b0, STEP_W};
    if (do_dec && (duty_q != '0)) begin
      duty_d = (duty_q < STEP_W) ? '0 : duty_q - STEP_W;
      wr_d   = 1'b1;
    end else if (do_inc && (duty_q < LIMIT_W)) begin
      duty_d = (sum > MAX_X) ? MAX_X[WIDTH-1:0] : sum[WIDTH-1:0];
      wr_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      duty_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      if (wr_d) duty_q <= duty_d;
    end
  end

  assign duty_o = duty_q;
  assign wr_o   = wr_q;
endmodule

// File: rtl/duty_stepper.sv
module duty_stepper
  import duty_step_pkg::*;
#(
  parameter int WIDTH           = 8,
  parameter int STEP            = 15,
  parameter int UP_LIMIT        = 250,
  parameter int DEBOUNCE_CYCLES = 20000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_dn_n,
  input  logic             btn_up_n,
  output logic [WIDTH-1:0] duty_o,
  output logic             duty_wr_o
);
  logic               rst_ns;
  logic [NUM_BTN-1:0] raw_n;
  logic [NUM_BTN-1:0] sync_n;
  logic [NUM_BTN-1:0] pressed;

  assign raw_n[BTN_DN] = btn_dn_n;
  assign raw_n[BTN_UP] = btn_up_n;

  rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_ns),
      .din   (raw_n[g]),
      .dout  (sync_n[g])
    );
    btn_debounce #(.HOLD_CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk       (clk),
      .rst_n     (rst_ns),
      .level_i   (sync_n[g]),
      .pressed_o (pressed[g])
    );
  end

  duty_arbiter #(
    .WIDTH    (WIDTH),
    .STEP     (STEP),
    .UP_LIMIT (UP_LIMIT)
  ) u_arb (
    .clk    (clk),
    .rst_n  (rst_ns),
    .dn_p   (pressed[BTN_DN]),
    .up_p   (pressed[BTN_UP]),
    .duty_o (duty_o),
    .wr_o   (duty_wr_o)
  );
endmodule

// File: rtl/duty_stepper_chk.sv
module duty_stepper_chk #(
  parameter int WIDTH    = 8,
  parameter int STEP     = 15,
  parameter int UP_LIMIT = 250
) (
  input logic             clk,
  input logic             rst_ns,
  input logic [WIDTH-1:0] duty,
  input logic             wr,
  input logic             dn_p,
  input logic             up_p
);
  localparam logic [WIDTH-1:0] STEP_W  = WIDTH'(STEP);
  localparam logic [WIDTH-1:0] LIMIT_W = WIDTH'(UP_LIMIT);
  localparam logic [WIDTH-1:0] MAX_W   = {WIDTH{1'b1}};

  // R8
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    wr |=> !wr);

  // R8
  change_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (duty != $past(duty)) |-> wr);

  // R8
  strobe_means_change_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    wr |-> (duty != $past(duty)));

  // R5
  inc_limit_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr && (duty > $past(duty))) |-> ($past(duty) < LIMIT_W));

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr && (duty > $past(duty))) |-> ((duty - $past(duty) == STEP_W) || (duty == MAX_W)));

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr && (duty < $past(duty))) |-> (($past(duty) - duty == STEP_W) || (duty == '0)));

  // R3
  dec_after_release_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr && (duty < $past(duty))) |-> !$past(dn_p));

  // R9
  inc_needs_both_up_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr && (duty > $past(duty))) |-> (!$past(up_p) && !$past(dn_p)));
endmodule

bind duty_stepper duty_stepper_chk #(
  .WIDTH    (WIDTH),
  .STEP     (STEP),
  .UP_LIMIT (UP_LIMIT)
) u_chk (
  .clk    (clk),
  .rst_ns (rst_ns),
  .duty   (duty_o),
  .wr     (duty_wr_o),
  .dn_p   (pressed[0]),
  .up_p   (pressed[1])
);

// File: tb/duty_stepper_test.sv
`timescale 1ns/1ps
module duty_stepper_test;
  localparam int DEB    = 16;
  localparam int SETTLE = DEB + 30;

  logic       clk;
  logic       rst_n;
  logic       btn_dn_n;
  logic       btn_up_n;
  logic [7:0] duty_o;
  logic       duty_wr_o;

  int n_tests;
  int n_fail;
  int wr_count;
  bit done;

  duty_stepper #(.DEBOUNCE_CYCLES(DEB)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_dn_n  (btn_dn_n),
    .btn_up_n  (btn_up_n),
    .duty_o    (duty_o),
    .duty_wr_o (duty_wr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) wr_count <= 0;
    else if (duty_wr_o) wr_count <= wr_count + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input bit dn, input int hold);
    @(negedge clk);
    if (dn) btn_dn_n = 1'b0; else btn_up_n = 1'b0;
    idle(hold);
    if (dn) btn_dn_n = 1'b1; else btn_up_n = 1'b1;
    idle(SETTLE);
  endtask

  task automatic t_reset();
    check("R6 duty after reset", duty_o, 0);
    check("R6 strobe after reset", duty_wr_o, 0);
    idle(200);
    check("R1 idle high inputs strobes", wr_count, 0);
    check("R1 idle high inputs duty", duty_o, 0);
  endtask

  task automatic t_dec_at_zero();
    int c0 = wr_count;
    press(1'b1, 40);
    check("R4 dec at zero duty", duty_o, 0);
    check("R4 dec at zero strobes", wr_count - c0, 0);
  endtask

  task automatic t_hold_then_release();
    int c0 = wr_count;
    @(negedge clk);
    btn_up_n = 1'b0;
    idle(150);
    check("R3 held value", duty_o, 0);
    check("R3 held strobes", wr_count - c0, 0);
    btn_up_n = 1'b1;
    idle(DEB + 6);
    check("R2 inc after release", duty_o, 15);
    check("R8 one strobe per step", wr_count - c0, 1);
    idle(20);
  endtask

  task automatic t_glitch();
    int c0 = wr_count;
    @(negedge clk);
    btn_up_n = 1'b0;
    idle(DEB / 2);
    btn_up_n = 1'b1;
    idle(SETTLE);
    check("R7 short pulse duty", duty_o, 15);
    check("R7 short pulse strobes", wr_count - c0, 0);
  endtask

  task automatic t_bounce();
    int c0 = wr_count;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); btn_up_n = 1'b0; idle(3);
      btn_up_n = 1'b1; idle(2);
    end
    btn_up_n = 1'b0;
    idle(60);
    for (int i = 0; i < 6; i++) begin
      btn_up_n = 1'b1; idle(2);
      btn_up_n = 1'b0; idle(3);
    end
    btn_up_n = 1'b1;
    idle(SETTLE);
    check("R7 bouncy press duty", duty_o, 30);
    check("R7 bouncy press strobes", wr_count - c0, 1);
  endtask

  task automatic t_climb();
    int c0 = wr_count;
    for (int i = 0; i < 14; i++) press(1'b0, 30);
    check("R5 below limit at 240", duty_o, 240);
    press(1'b0, 30);
    check("R5 inc from 240", duty_o, 255);
    check("R8 strobes on climb", wr_count - c0, 15);
    c0 = wr_count;
    press(1'b0, 30);
    check("R5 inc at 255 duty", duty_o, 255);
    check("R5 inc at 255 strobes", wr_count - c0, 0);
  endtask

  task automatic t_down();
    int c0 = wr_count;
    press(1'b1, 30);
    check("R2 dec from 255", duty_o, 240);
    check("R8 dec strobe", wr_count - c0, 1);
  endtask

  task automatic t_both_dn_first();
    int c0 = wr_count;
    @(negedge clk);
    btn_dn_n = 1'b0; idle(60);
    btn_up_n = 1'b0; idle(60);
    btn_dn_n = 1'b1; idle(SETTLE);
    check("R9 dn first, dn released", duty_o, 225);
    btn_up_n = 1'b1; idle(SETTLE);
    check("R9 dn first, up dropped", duty_o, 225);
    check("R9 dn first strobes", wr_count - c0, 1);
  endtask

  task automatic t_both_up_first();
    int c0 = wr_count;
    @(negedge clk);
    btn_up_n = 1'b0; idle(60);
    btn_dn_n = 1'b0; idle(60);
    check("R9 up first, both held", duty_o, 225);
    btn_dn_n = 1'b1; idle(SETTLE);
    check("R9 up first, dn released", duty_o, 210);
    btn_dn_n = 1'b0; idle(60);
    btn_dn_n = 1'b1; idle(SETTLE);
    check("R9 dn press while locked", duty_o, 210);
    btn_up_n = 1'b1; idle(SETTLE);
    check("R9 up first, up dropped", duty_o, 210);
    check("R9 up first strobes", wr_count - c0, 1);
    press(1'b0, 30);
    check("R9 press after unlock", duty_o, 225);
  endtask

  initial begin
    n_tests  = 0;
    n_fail   = 0;
    done     = 1'b0;
    btn_dn_n = 1'b1;
    btn_up_n = 1'b1;
    rst_n    = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_dec_at_zero();
    t_hold_then_release();
    t_glitch();
    t_bounce();
    t_climb();
    t_down();
    t_both_dn_first();
    t_both_up_first();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule